// File: doc/BRIEF.md
# PRBS Sync Monitor

The block watches a serial bit stream, qualified by a bit-valid strobe, and predicts each bit with its own 15-stage pseudo-random generator. When the stream carries the expected pseudo-random pattern, the prediction lines up with the input and the monitor declares itself in sync. When the prediction and the stream keep disagreeing, it declares loss of sync. The input carries no framing: the pattern runs continuously and is checked bit by bit.

Locking uses hysteresis. After reset the monitor starts out of sync. While out of sync, it loads every received bit straight into its generator register, so the register takes on the incoming phase after one register length of bits. A long run of consecutive correct predictions declares sync. Once in sync, the generator runs freely on its own predictions. A single corrupted input bit then causes exactly one error indication and no more. A shorter run of consecutive wrong predictions drops the monitor back out of sync.

While in sync, each wrong prediction produces a one-cycle bit-error pulse. Counting those pulses is left to logic outside the block.

Top module: `prbs_sync_monitor`

## Requirements
- R1: During and right after synchronous reset, `oos` is 1 and `bit_err` is 0. The generator register resets to all ones.
- R2: On a cycle with `bit_vld` low, `bit_in` is ignored. The generator register, both run counts and `oos` keep their values, and `bit_err` is 0 in the following cycle.
- R3: The predicted bit is the XOR of register stages 15 and 14 (bits [14] and [13]), which gives the polynomial x^15 + x^14 + 1. On each valid bit the register shifts toward bit [14], and the new bit enters at bit [0].
- R4: While out of sync, the bit that enters the register on a valid cycle is the received `bit_in`. A clean pattern therefore locks within 15 + 32 valid bits.
- R5: While out of sync, the valid bit that completes 32 consecutive correct predictions clears `oos` at the clock edge that samples it. Both run counts then restart from zero.
- R6: A wrong prediction restarts the run of correct predictions from zero. Until 32 further consecutive correct predictions arrive, the monitor stays out of sync.
- R7: While in sync, the valid bit that completes 4 consecutive wrong predictions sets `oos` at the clock edge that samples it. Both run counts then restart from zero.
- R8: A correct prediction restarts the run of wrong predictions from zero. For example, 3 errors, then 1 good bit, then 3 more errors leave the monitor in sync.
- R9: While in sync, every valid bit that differs from the prediction raises `bit_err` for exactly one cycle, the cycle after the edge that samples that bit. This also holds for the bit that causes loss of sync.
- R10: `bit_err` stays 0 for every bit sampled while the monitor is out of sync.
- R11: While in sync, the bit that enters the register is the prediction, not `bit_in`. One corrupted bit in an otherwise clean pattern gives exactly one `bit_err` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Qualifies `bit_in` for this cycle |
| bit_in | input | 1 | Received serial data bit |
| oos | output | 1 | Out-of-sync status, 1 = not locked |
| bit_err | output | 1 | One-cycle pulse for a mismatched bit while in sync |

## Verification
The bench builds the monitor with its default parameters: a 15-stage generator with taps 15 and 14, a lock run of 32 and a loss run of 4. A loss run of 4 lets short error bursts of 3 bits, and bursts broken by one good bit, sit right at the edge of dropping sync. A lock run of 32 makes a single mismatch after exactly 31 matches a reachable corner while the monitor is hunting. Random strobe gaps and randomly placed errors and bursts then drive the monitor through repeated losses of sync and relocks.

// File: rtl/prbs_mon_pkg.sv
package prbs_mon_pkg;

    typedef enum logic {
        SS_HUNT   = 1'b0,
        SS_LOCKED = 1'b1
    } sync_state_e;

    typedef struct packed {
        logic pred;
        logic hit;
    } bit_eval_t;

    function automatic logic masked_parity(input logic [63:0] s, input logic [63:0] m);
        return ^(s & m);
    endfunction

endpackage

// File: rtl/prbs_ref_gen.sv
module prbs_ref_gen #(
    parameter int LEN   = 15,
    parameter int TAP_A = 15,
    parameter int TAP_B = 14
) (
    input  logic clk,
    input  logic rst,
    input  logic adv,
    input  logic hunt,
    input  logic bit_in,
    output logic pred
);
    import prbs_mon_pkg::*;

    localparam logic [LEN-1:0] TAP_MASK = LEN'((64'd1 << (TAP_A - 1)) | (64'd1 << (TAP_B - 1)));

    logic [LEN-1:0] state;
    logic           fill_bit;

    assign pred     = masked_parity(64'(state), 64'(TAP_MASK));
    assign fill_bit = hunt ? bit_in : pred;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= '1;
        end else if (adv) begin
            state <= {state[LEN-2:0], fill_bit};
        end
    end

    // R4: while hunting, the received bit is what enters the register
    p_seed_from_input_r4: assert property (@(posedge clk) disable iff (rst)
        (adv && hunt) |=> (state[0] == $past(bit_in)));

    // R2: the register holds when no valid bit arrives
    p_hold_when_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !adv |=> $stable(state));

endmodule

// File: rtl/run_counter.sv
module run_counter #(
    parameter int LIMIT = 32,
    localparam int W    = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && count != W'(LIMIT)) begin
            count <= count + 1'b1;
        end
    end

    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        count <= W'(LIMIT));

endmodule

// File: rtl/sync_fsm.sv
module sync_fsm #(
    parameter int LOCK_RUN = 32,
    parameter int LOSE_RUN = 4,
    localparam int MW      = $clog2(LOCK_RUN + 1),
    localparam int LW      = $clog2(LOSE_RUN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_vld,
    input  logic          hit,
    input  logic [MW-1:0] match_run,
    input  logic [LW-1:0] miss_run,
    output logic          inc_match,
    output logic          clr_match,
    output logic          inc_miss,
    output logic          clr_miss,
    output logic          oos,
    output logic          bit_err
);
    import prbs_mon_pkg::*;

    sync_state_e state;
    logic        lock_now;
    logic        drop_now;
    logic        flip;

    always_comb begin
        lock_now  = bit_vld && (state == SS_HUNT)   &&  hit && (match_run == MW'(LOCK_RUN - 1));
        drop_now  = bit_vld && (state == SS_LOCKED) && !hit && (miss_run  == LW'(LOSE_RUN - 1));
        flip      = lock_now || drop_now;
        inc_match = bit_vld && hit;
        inc_miss  = bit_vld && !hit;
        clr_match = flip || (bit_vld && !hit);
        clr_miss  = flip || (bit_vld && hit);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= SS_HUNT;
            bit_err <= 1'b0;
        end else begin
            if (lock_now) state <= SS_LOCKED;
            else if (drop_now) state <= SS_HUNT;
            bit_err <= bit_vld && (state == SS_LOCKED) && !hit;
        end
    end

    assign oos = (state == SS_HUNT);

    // R10: an error pulse only follows a bit sampled while in sync
    p_err_only_sync_r10: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> !$past(oos));

    // R9: an error pulse needs a valid bit
    p_err_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
        bit_err |-> $past(bit_vld));

    // R2: status holds across idle cycles
    p_status_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(oos));

    // R5: lock only at the end of a full match run
    p_lock_after_run_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(oos) |-> ($past(match_run) == MW'(LOCK_RUN - 1) && $past(hit)));

    // R7: loss only at the end of a full miss run
    p_lose_after_run_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(oos) |-> ($past(miss_run) == LW'(LOSE_RUN - 1) && !$past(hit)));

endmodule

// File: rtl/prbs_sync_monitor.sv
module prbs_sync_monitor #(
    parameter int PRBS_LEN = 15,
    parameter int TAP_A    = 15,
    parameter int TAP_B    = 14,
    parameter int LOCK_RUN = 32,
    parameter int LOSE_RUN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic oos,
    output logic bit_err
);
    import prbs_mon_pkg::*;

    localparam int MW = $clog2(LOCK_RUN + 1);
    localparam int LW = $clog2(LOSE_RUN + 1);

    bit_eval_t     ev;
    logic [MW-1:0] match_run;
    logic [LW-1:0] miss_run;
    logic          inc_match, clr_match, inc_miss, clr_miss;

    prbs_ref_gen #(.LEN(PRBS_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_gen (
        .clk    (clk),
        .rst    (rst),
        .adv    (bit_vld),
        .hunt   (oos),
        .bit_in (bit_in),
        .pred   (ev.pred)
    );

    assign ev.hit = (bit_in == ev.pred);

    run_counter #(.LIMIT(LOCK_RUN)) u_match_run (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_match),
        .inc   (inc_match),
        .count (match_run)
    );

    run_counter #(.LIMIT(LOSE_RUN)) u_miss_run (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr_miss),
        .inc   (inc_miss),
        .count (miss_run)
    );

    sync_fsm #(.LOCK_RUN(LOCK_RUN), .LOSE_RUN(LOSE_RUN)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .bit_vld   (bit_vld),
        .hit       (ev.hit),
        .match_run (match_run),
        .miss_run  (miss_run),
        .inc_match (inc_match),
        .clr_match (clr_match),
        .inc_miss  (inc_miss),
        .clr_miss  (clr_miss),
        .oos       (oos),
        .bit_err   (bit_err)
    );

    // R1: reset leaves the monitor hunting and quiet
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (oos && !bit_err));

endmodule

// File: tb/prbs_sync_monitor_bench.sv
`timescale 1ns/1ps
module prbs_sync_monitor_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_vld = 1'b0;
    logic bit_in = 1'b0;
    logic oos, bit_err;

    always #10 clk = ~clk;

    prbs_sync_monitor u_prbs_sync_monitor (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
        .oos(oos), .bit_err(bit_err)
    );

    int   checks = 0;
    int   errors = 0;
    int   pulses = 0;
    bit   done   = 1'b0;

    logic [14:0] m_lfsr;
    int          m_match, m_miss;
    logic        m_oos, m_err;
    logic [14:0] tx;

    task automatic check(input logic cond, input string tag, input int act, input int exp);
        checks++;
        if (!cond) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic tx_bit();
        logic b;
        b  = tx[14] ^ tx[13];
        tx = {tx[13:0], b};
        return b;
    endfunction

    task automatic model_reset();
        m_lfsr = '1; m_match = 0; m_miss = 0; m_oos = 1'b1; m_err = 1'b0;
    endtask

    task automatic model_step(input logic v, input logic b);
        logic e;
        logic hit;
        if (!v) begin
            m_err = 1'b0;
        end else begin
            e      = m_lfsr[14] ^ m_lfsr[13];
            hit    = (b == e);
            m_err  = !m_oos && !hit;
            m_lfsr = {m_lfsr[13:0], (m_oos ? b : e)};
            if (hit) begin
                m_match++; m_miss = 0;
                if (m_oos && m_match == 32) begin m_oos = 1'b0; m_match = 0; end
            end else begin
                m_miss++; m_match = 0;
                if (!m_oos && m_miss == 4) begin m_oos = 1'b1; m_miss = 0; end
            end
        end
    endtask

    // drive at a falling edge, sample at the next falling edge
    task automatic do_bit(input logic v, input logic b, input string ph);
        logic  prev;
        string tag;
        bit_vld = v; bit_in = b;
        @(posedge clk);
        prev = m_oos;
        model_step(v, b);
        @(negedge clk);
        if (prev && !m_oos)      tag = "R5";
        else if (!prev && m_oos) tag = "R7";
        else if (!v)             tag = "R2";
        else if (m_err)          tag = "R9";
        else if (m_oos)          tag = "R10";
        else                     tag = "R11";
        if (bit_err) pulses++;
        check(oos == m_oos, {ph, "/", tag, " oos"}, int'(oos), int'(m_oos));
        check(bit_err == m_err, {ph, "/", tag, " bit_err"}, int'(bit_err), int'(m_err));
    endtask

    task automatic good(input int n, input string ph);
        for (int i = 0; i < n; i++) do_bit(1'b1, tx_bit(), ph);
    endtask

    task automatic bad(input int n, input string ph);
        for (int i = 0; i < n; i++) do_bit(1'b1, !tx_bit(), ph);
    endtask

    task automatic do_reset();
        rst = 1'b1; bit_vld = 1'b0;
        repeat (3) @(negedge clk);
        check(oos == 1'b1 && bit_err == 1'b0, "R1 reset", int'({oos, bit_err}), 2);
        rst = 1'b0;
        model_reset();
    endtask

    initial begin
        int burst;
        void'($urandom(32'h5EED));
        tx = 15'h1ACE;
        do_reset();

        // R4/R3: clean pattern locks within 47 valid bits
        good(47, "R4");
        check(oos == 1'b0, "R4 locked by bit 47", int'(oos), 0);

        // R2: idle cycles with toggling data change nothing
        for (int i = 0; i < 10; i++) do_bit(1'b0, i[0], "R2");
        pulses = 0;
        good(20, "R3");
        check(pulses == 0, "R3 prediction continues after idle", pulses, 0);

        // R11: one corrupted bit gives one pulse
        pulses = 0;
        bad(1, "R11"); good(20, "R11");
        check(pulses == 1, "R11 single pulse", pulses, 1);

        // R8: 3 errors, 1 good, 3 errors stays in sync
        pulses = 0;
        bad(3, "R8"); good(1, "R8"); bad(3, "R8");
        check(oos == 1'b0, "R8 still in sync", int'(oos), 0);
        check(pulses == 6, "R8 six pulses", pulses, 6);
        good(5, "R8");

        // R7/R9: 4 errors drop sync, each pulses
        pulses = 0;
        bad(4, "R7");
        check(oos == 1'b1, "R7 lost sync", int'(oos), 1);
        check(pulses == 4, "R9 four pulses", pulses, 4);

        // R6: mismatch after 31 matches keeps hunting
        do_reset();
        for (int i = 0; i < 200 && !(m_oos && m_match == 31); i++) good(1, "R6");
        check(m_oos && m_match == 31, "R6 reached 31 matches", m_match, 31);
        bad(1, "R6");
        check(oos == 1'b1, "R6 still hunting", int'(oos), 1);
        pulses = 0;
        good(60, "R6");
        check(oos == 1'b0, "R5 relocked", int'(oos), 0);
        check(pulses == 0, "R10 no pulses while hunting", pulses, 0);

        // random mix: strobe gaps, lone errors, bursts
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = int'($urandom_range(0, 99));
            if (r < 20) do_bit(1'b0, 1'($urandom), "RND");
            else if (r < 22) bad(1, "RND");
            else if (r == 22) begin
                burst = int'($urandom_range(2, 6));
                bad(burst, "RND");
            end else good(1, "RND");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule